// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from an accepted exception request to the first instruction of its handler. The request carries a vector number and two flags, one marking a reset and one marking an interrupt. Alongside it come the current status word, the program counter, the vector table base and the two supervisor stack pointers. The block captures all of them when it accepts the request. It then works through a word-wide memory port with a valid/ready handshake.

For an ordinary exception the block does the following:
- It pushes a four-word context record onto the active supervisor stack.
- If an interrupt arrives while the master-mode bit is set, it clears that bit and pushes a second record on the interrupt stack.
- It fetches the handler address from the vector table.
- It reads the first three handler words into a prefetch queue.
- It raises a one-cycle done pulse.

A reset request writes nothing. It loads the interrupt stack pointer and then the program counter from the first two table entries, prefetches, and finishes the same way. The updated status word, program counter and stack pointers are presented on outputs and are valid when done is high.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is high and `done` and `mem_valid` are low. `busy` stays high for the first two rising edges after release and falls after that, with `mem_valid` still low.
- R2: A 32-bit table entry for index n lies at byte address `vbr_in + 4*n`. The high 16-bit word is read at that address and the low word at the address plus 2. For a non-reset request, n is `req_vec`, and the entry read becomes `out_pc`.
- R3: For a non-reset request, four words are written onto the active supervisor stack. The active stack is `msp_in` when bit 12 of `sr_in` is set, otherwise `isp_in`. Each write first lowers that pointer by 2. The word at SP-2 is PC[15:0] and the word at SP-4 is PC[31:16]. The word at SP-6 is the old status word. The word at SP-8 is the format word `{4'h0, 2'b00, vec[7:0], 2'b00}`.
- R4: When `req_irq` is set and bit 12 of `sr_in` is set, `out_sr` has bit 12 cleared. After the first record, a second four-word record is written on the interrupt stack with the same layout, carrying the new status word and format code 4'h1 in bits 15:12.
- R5: For a non-reset request, `out_sr` equals `sr_in` with bit 13 (supervisor) set. Bit 12 is cleared only as R4 states.
- R6: A reset request performs no write. It reads the interrupt stack pointer from index 0 into `out_isp` and the program counter from index 1 into `out_pc`. It sets `out_sr` to 16'h2700, and `out_msp` keeps `msp_in`.
- R7: After the program counter is loaded, three words are read from `out_pc`, `out_pc+2` and `out_pc+4`. They appear in `pf_words` slices [15:0], [31:16] and [47:32] respectively, and `done` rises after the third read.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` hold. Every access completes on the first rising edge where both are high, so a sequence of N accesses with L wait cycles each takes N*(L+1) cycles from acceptance to `done`.
- R9: `done` is high for exactly one cycle per accepted request, and `busy` is high from the cycle after acceptance through the `done` cycle.
- R10: A request presented while `busy` is high is ignored. It produces no access, no output change and no `done`.
- R11: At `done`, `out_msp` and `out_isp` hold the stack pointers after all pushes. A pointer drops by 8 for each record placed on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request, taken when busy is low |
| req_vec | input | 8 | Vector number |
| req_reset | input | 1 | Request is a reset |
| req_irq | input | 1 | Request is an interrupt |
| sr_in | input | 16 | Status word before the exception |
| pc_in | input | 32 | Program counter to save |
| vbr_in | input | 32 | Vector table base address |
| msp_in | input | 32 | Master stack pointer |
| isp_in | input | 32 | Interrupt stack pointer |
| busy | output | 1 | Sequence running or reset not yet released |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data |
| out_pc | output | 32 | Handler program counter |
| out_sr | output | 16 | Updated status word |
| out_msp | output | 32 | Master stack pointer after entry |
| out_isp | output | 32 | Interrupt stack pointer after entry |
| pf_words | output | 48 | Prefetched handler words, first word lowest |

## Verification
The bound checker watches several properties on every cycle:
- the handshake holds while the port waits;
- `done` is a single-cycle pulse inside `busy`;
- a reset sequence never writes;
- an idle sequencer is silent on the port;
- at each `done`, the number of reads (five or seven) and writes (zero, four or eight) matches the kind of request;
- the supervisor bit is set, and the master-mode bit is clear after a double-record entry.

The data itself can only be shown by the bench's scenarios against its memory model. That covers the record layout and the addresses it lands on, the vector table arithmetic for several bases and vectors up to 255, the prefetched words, the exact cycle count under different wait lengths, and the rejection of a request that arrives mid-sequence.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH,
    ST_PUSH2,
    ST_SP_HI,
    ST_SP_LO,
    ST_VEC_HI,
    ST_VEC_LO,
    ST_PREF,
    ST_DONE
  } seq_state_e;

  localparam int SR_S_BIT    = 13;
  localparam int SR_M_BIT    = 12;
  localparam int FRAME_WORDS = 4;
  localparam logic [15:0] SR_AT_RESET = 16'h2700;
  localparam logic [3:0]  FMT_PRIMARY = 4'h0;
  localparam logic [3:0]  FMT_SECOND  = 4'h1;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VEC_W-1:0]  idx,
  output logic [ADDR_W-1:0] entry_hi,
  output logic [ADDR_W-1:0] entry_lo
);
  logic [ADDR_W-1:0] offset;

  assign offset   = {{(ADDR_W-VEC_W-2){1'b0}}, idx, 2'b00};
  assign entry_hi = base + offset;
  assign entry_lo = entry_hi + ADDR_W'(2);
endmodule

// File: rtl/exc_frame_word.sv
module exc_frame_word #(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic [1:0]          slot,
  input  logic [2*WORD_W-1:0] pc,
  input  logic [WORD_W-1:0]   sr,
  input  logic [3:0]          fmt_code,
  input  logic [VEC_W-1:0]    vec,
  output logic [WORD_W-1:0]   word
);
  localparam int PAD_W = WORD_W - 4 - VEC_W - 2;

  always_comb begin
    case (slot)
      2'd0:    word = pc[WORD_W-1:0];
      2'd1:    word = pc[2*WORD_W-1:WORD_W];
      2'd2:    word = sr;
      default: word = {fmt_code, {PAD_W{1'b0}}, vec, 2'b00};
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int VEC_W    = 8,
  parameter int PF_WORDS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [VEC_W-1:0]             req_vec,
  input  logic                         req_reset,
  input  logic                         req_irq,
  input  logic [ADDR_W/2-1:0]          sr_in,
  input  logic [ADDR_W-1:0]            pc_in,
  input  logic [ADDR_W-1:0]            vbr_in,
  input  logic [ADDR_W-1:0]            msp_in,
  input  logic [ADDR_W-1:0]            isp_in,
  output logic                         busy,
  output logic                         done,
  output logic                         mem_valid,
  output logic                         mem_write,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [ADDR_W/2-1:0]          mem_wdata,
  input  logic                         mem_ready,
  input  logic [ADDR_W/2-1:0]          mem_rdata,
  output logic [ADDR_W-1:0]            out_pc,
  output logic [ADDR_W/2-1:0]          out_sr,
  output logic [ADDR_W-1:0]            out_msp,
  output logic [ADDR_W-1:0]            out_isp,
  output logic [PF_WORDS*ADDR_W/2-1:0] pf_words
);
  localparam int WORD_W = ADDR_W / 2;
  localparam int CNT_W  = (PF_WORDS > FRAME_WORDS) ? $clog2(PF_WORDS) : $clog2(FRAME_WORDS);
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_PF    = CNT_W'(PF_WORDS - 1);

  logic              rst_sync_n;
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [VEC_W-1:0]  vec_q, idx;
  logic              rst_q, two_q, sec_frame;
  logic [WORD_W-1:0] sr_old_q, sr_new_q, sr_new_d;
  logic [ADDR_W-1:0] pc_q, vbr_q, msp_q, isp_q, npc_q, act_sp;
  logic [ADDR_W-1:0] ent_hi, ent_lo;
  logic              accept, xfer;
  logic [WORD_W-1:0] pf_q [PF_WORDS];

  exc_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  exc_vec_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_vaddr (
    .base(vbr_q), .idx(idx), .entry_hi(ent_hi), .entry_lo(ent_lo)
  );

  exc_frame_word #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_frame (
    .slot(cnt_q[1:0]), .pc(pc_q), .sr(sec_frame ? sr_new_q : sr_old_q),
    .fmt_code(sec_frame ? FMT_SECOND : FMT_PRIMARY), .vec(vec_q), .word(mem_wdata)
  );

  assign accept = req_valid && (state_q == ST_IDLE);
  assign xfer   = mem_valid && mem_ready;
  assign busy   = !rst_sync_n || (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);
  assign act_sp = sr_old_q[SR_M_BIT] ? msp_q : isp_q;

  assign sr_new_d = req_reset ? SR_AT_RESET
                  : (sr_in | (WORD_W'(1) << SR_S_BIT))
                    & ~((req_irq && sr_in[SR_M_BIT]) ? (WORD_W'(1) << SR_M_BIT) : '0);

  // Access decode
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    idx       = vec_q;
    sec_frame = 1'b0;
    case (state_q)
      ST_PUSH:   begin mem_valid = 1'b1; mem_write = 1'b1; mem_addr = act_sp - ADDR_W'(2); end
      ST_PUSH2:  begin mem_valid = 1'b1; mem_write = 1'b1; sec_frame = 1'b1;
                       mem_addr = isp_q - ADDR_W'(2); end
      ST_SP_HI:  begin mem_valid = 1'b1; idx = '0; mem_addr = ent_hi; end
      ST_SP_LO:  begin mem_valid = 1'b1; idx = '0; mem_addr = ent_lo; end
      ST_VEC_HI: begin mem_valid = 1'b1; idx = rst_q ? VEC_W'(1) : vec_q; mem_addr = ent_hi; end
      ST_VEC_LO: begin mem_valid = 1'b1; idx = rst_q ? VEC_W'(1) : vec_q; mem_addr = ent_lo; end
      ST_PREF:   begin mem_valid = 1'b1;
                       mem_addr = npc_q + {{(ADDR_W-CNT_W-1){1'b0}}, cnt_q, 1'b0}; end
      default:   ;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE:   if (accept) begin state_d = req_reset ? ST_SP_HI : ST_PUSH; cnt_d = '0; end
      ST_PUSH:   if (xfer) begin
                   cnt_d = cnt_q + 1'b1;
                   if (cnt_q == LAST_FRAME) begin
                     cnt_d   = '0;
                     state_d = two_q ? ST_PUSH2 : ST_VEC_HI;
                   end
                 end
      ST_PUSH2:  if (xfer) begin
                   cnt_d = cnt_q + 1'b1;
                   if (cnt_q == LAST_FRAME) begin cnt_d = '0; state_d = ST_VEC_HI; end
                 end
      ST_SP_HI:  if (xfer) state_d = ST_SP_LO;
      ST_SP_LO:  if (xfer) state_d = ST_VEC_HI;
      ST_VEC_HI: if (xfer) state_d = ST_VEC_LO;
      ST_VEC_LO: if (xfer) begin state_d = ST_PREF; cnt_d = '0; end
      ST_PREF:   if (xfer) begin
                   cnt_d = cnt_q + 1'b1;
                   if (cnt_q == LAST_PF) begin cnt_d = '0; state_d = ST_DONE; end
                 end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q    <= '0;
      rst_q    <= 1'b0;
      two_q    <= 1'b0;
      sr_old_q <= '0;
      sr_new_q <= '0;
      pc_q     <= '0;
      vbr_q    <= '0;
    end else if (accept) begin
      vec_q    <= req_vec;
      rst_q    <= req_reset;
      two_q    <= req_irq && sr_in[SR_M_BIT] && !req_reset;
      sr_old_q <= sr_in;
      sr_new_q <= sr_new_d;
      pc_q     <= pc_in;
      vbr_q    <= vbr_in;
    end
  end

  // Stack pointers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      msp_q <= '0;
      isp_q <= '0;
    end else if (accept) begin
      msp_q <= msp_in;
      isp_q <= isp_in;
    end else if (xfer) begin
      case (state_q)
        ST_PUSH:  if (sr_old_q[SR_M_BIT]) msp_q <= msp_q - ADDR_W'(2);
                  else                    isp_q <= isp_q - ADDR_W'(2);
        ST_PUSH2: isp_q <= isp_q - ADDR_W'(2);
        ST_SP_HI: isp_q[ADDR_W-1:WORD_W] <= mem_rdata;
        ST_SP_LO: isp_q[WORD_W-1:0]      <= mem_rdata;
        default:  ;
      endcase
    end
  end

  // Handler address
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) npc_q <= '0;
    else if (xfer && state_q == ST_VEC_HI) npc_q[ADDR_W-1:WORD_W] <= mem_rdata;
    else if (xfer && state_q == ST_VEC_LO) npc_q[WORD_W-1:0]      <= mem_rdata;
  end

  // Prefetch queue
  for (genvar k = 0; k < PF_WORDS; k++) begin : g_pf
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) pf_q[k] <= '0;
      else if (xfer && state_q == ST_PREF && cnt_q == CNT_W'(k)) pf_q[k] <= mem_rdata;
    end
    assign pf_words[k*WORD_W +: WORD_W] = pf_q[k];
  end

  assign out_pc  = npc_q;
  assign out_sr  = sr_new_q;
  assign out_msp = msp_q;
  assign out_isp = isp_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_reset,
  input logic        req_irq,
  input logic [15:0] sr_in,
  input logic        busy,
  input logic        done,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ready,
  input logic [15:0] out_sr
);
  logic       rst_path, two_frame;
  logic [3:0] rd_cnt, wr_cnt;
  logic       acc;

  assign acc = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_path  <= 1'b0;
      two_frame <= 1'b0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
    end else if (acc) begin
      rst_path  <= req_reset;
      two_frame <= req_irq && sr_in[12] && !req_reset;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
    end else if (mem_valid && mem_ready) begin
      if (mem_write) wr_cnt <= wr_cnt + 1'b1;
      else           rd_cnt <= rd_cnt + 1'b1;
    end
  end

  AST_HOLD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !done); // R10
  AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_path && mem_valid |-> !mem_write); // R6
  AST_READ_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_cnt == (rst_path ? 4'd7 : 4'd5)); // R7
  AST_WRITE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_cnt == (rst_path ? 4'd0 : (two_frame ? 4'd8 : 4'd4))); // R3
  AST_SUPERVISOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !rst_path |-> out_sr[13]); // R5
  AST_MASTER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done && two_frame |-> !out_sr[12]); // R4
endmodule

bind exc_entry_seq exc_entry_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reset(req_reset),
  .req_irq(req_irq), .sr_in(sr_in), .busy(busy), .done(done),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .out_sr(out_sr)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk, rst_n;
  logic        req_valid, req_reset, req_irq;
  logic [7:0]  req_vec;
  logic [15:0] sr_in;
  logic [31:0] pc_in, vbr_in, msp_in, isp_in;
  logic        busy, done, mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, out_pc, out_msp, out_isp;
  logic [15:0] mem_wdata, mem_rdata, out_sr;
  logic [47:0] pf_words;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int wcnt     = 0;
  int wr_count = 0;
  logic [15:0] mem [2048];

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_reset(req_reset), .req_irq(req_irq), .sr_in(sr_in), .pc_in(pc_in),
    .vbr_in(vbr_in), .msp_in(msp_in), .isp_in(isp_in), .busy(busy), .done(done),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .out_pc(out_pc), .out_sr(out_sr), .out_msp(out_msp), .out_isp(out_isp),
    .pf_words(pf_words)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:1]];

  always @(negedge clk) begin
    if (mem_valid) begin
      if (wcnt >= lat) begin mem_ready <= 1'b1; wcnt <= 0; end
      else begin mem_ready <= 1'b0; wcnt <= wcnt + 1; end
    end else begin
      mem_ready <= 1'b0;
      wcnt <= 0;
    end
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) begin
      mem[mem_addr[11:1]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  function automatic logic [15:0] fill(input int i);
    return 16'h5A00 ^ 16'(i);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 2048; i++) mem[i] = fill(i);
    for (int b = 0; b < 2; b++)
      for (int v = 0; v < 256; v++) begin
        mem[(b*1024 + 4*v) / 2]     = 16'h0000;
        mem[(b*1024 + 4*v) / 2 + 1] = 16'(32'h0800 + 4*v);
      end
  endtask

  task automatic start_req(input logic [7:0] v, input logic irq, input logic rs,
                           input logic [15:0] sr, input logic [31:0] vbr);
    @(negedge clk);
    req_vec = v; req_irq = irq; req_reset = rs; sr_in = sr; vbr_in = vbr;
    pc_in = 32'h1234_0000 + 32'(v) * 2; msp_in = 32'h0E00; isp_in = 32'h0F00;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
  endtask

  task automatic check_pf(input string req, input logic [31:0] pc);
    for (int k = 0; k < 3; k++)
      check(req, pf_words[16*k +: 16], fill(int'(pc >> 1) + k));
  endtask

  // {vec, irq, sr, lat, vbr select}
  localparam logic [27:0] CASES [8] = '{
    {8'd2,   1'b0, 16'h0000, 2'd0, 1'b0},
    {8'd4,   1'b0, 16'h2000, 2'd1, 1'b1},
    {8'd5,   1'b0, 16'h1000, 2'd2, 1'b0},
    {8'd15,  1'b1, 16'h0000, 2'd0, 1'b1},
    {8'd25,  1'b1, 16'h3000, 2'd1, 1'b0},
    {8'd255, 1'b1, 16'h1700, 2'd0, 1'b1},
    {8'd9,   1'b0, 16'h3000, 2'd3, 1'b0},
    {8'd14,  1'b0, 16'h2000, 2'd0, 1'b1}
  };

  initial begin
    int cyc;
    req_valid = 0; req_reset = 0; req_irq = 0; req_vec = 0; sr_in = 0;
    pc_in = 0; vbr_in = 0; msp_in = 0; isp_in = 0; mem_ready = 0;
    mem_init();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1);
    check("R1 done in reset", done, 0);
    check("R1 valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after one edge", busy, 1);
    @(negedge clk);
    @(negedge clk);
    check("R1 busy released", busy, 0);
    check("R1 quiet port", mem_valid, 0);

    for (int i = 0; i < 8; i++) begin
      logic [7:0]  v;
      logic        irq, two;
      logic [15:0] sr, exp_sr, fmt;
      logic [31:0] vbr, act, pcx, hpc;
      int          nacc;
      {v, irq, sr} = CASES[i][27:3];
      lat = int'(CASES[i][2:1]);
      vbr = CASES[i][0] ? 32'h0400 : 32'h0000;
      two = irq && sr[12];
      exp_sr = (sr | 16'h2000) & (two ? 16'hEFFF : 16'hFFFF);
      act = sr[12] ? 32'h0E00 : 32'h0F00;
      pcx = 32'h1234_0000 + 32'(v) * 2;
      hpc = 32'h0800 + 32'(v) * 4;
      fmt = {4'h0, 2'b00, v, 2'b00};
      nacc = (two ? 8 : 4) + 5;
      mem_init();
      wr_count = 0;
      start_req(v, irq, 1'b0, sr, vbr);
      wait_done(cyc);
      check("R8 cycles to done", cyc, (lat + 1) * nacc + 1);
      check("R2 handler pc", out_pc, hpc);
      check("R5 status word", out_sr, exp_sr);
      check_pf("R7 prefetch", hpc);
      check("R3 write count", wr_count, two ? 8 : 4);
      check("R3 primary record",
            {mem[(act-8)/2], mem[(act-6)/2], mem[(act-4)/2], mem[(act-2)/2]},
            {fmt, sr, pcx[31:16], pcx[15:0]});
      if (two) begin
        check("R4 second record",
              {mem[(32'h0F00-8)/2], mem[(32'h0F00-6)/2], mem[(32'h0F00-4)/2], mem[(32'h0F00-2)/2]},
              {4'h1, fmt[11:0], exp_sr, pcx[31:16], pcx[15:0]});
        check("R4 master bit cleared", out_sr[12], 0);
      end
      check("R11 master sp", out_msp, sr[12] ? 32'h0DF8 : 32'h0E00);
      check("R11 interrupt sp", out_isp, (two || !sr[12]) ? 32'h0EF8 : 32'h0F00);
      @(negedge clk);
      check("R9 done single cycle", done, 0);
      check("R9 busy dropped", busy, 0);
    end

    // Reset request (R6)
    mem_init();
    mem[0] = 16'h0000; mem[1] = 16'h0F80; mem[2] = 16'h0000; mem[3] = 16'h0900;
    lat = 1; wr_count = 0;
    start_req(8'd7, 1'b0, 1'b1, 16'h0000, 32'h0);
    wait_done(cyc);
    check("R6 cycles", cyc, 2 * 7 + 1);
    check("R6 no writes", wr_count, 0);
    check("R6 stack pointer loaded", out_isp, 32'h0F80);
    check("R6 pc loaded", out_pc, 32'h0900);
    check("R6 status word", out_sr, 16'h2700);
    check("R6 master sp kept", out_msp, 32'h0E00);
    check_pf("R7 prefetch after reset", 32'h0900);

    // Request while busy (R10)
    mem_init();
    lat = 1; wr_count = 0;
    start_req(8'd4, 1'b0, 1'b0, 16'h0000, 32'h0);
    repeat (3) @(negedge clk);
    req_vec = 8'd8; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(cyc);
    check("R10 first request kept", out_pc, 32'h0810);
    check("R10 record vector", mem[(32'h0F00-8)/2], {4'h0, 2'b00, 8'd4, 2'b00});
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (done || mem_valid) extra++;
      end
      check("R10 no second sequence", extra, 0);
    end
    check("R10 no extra writes", wr_count, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule